// File: doc/BRIEF.md
# I2C Register Port Slave

This block is the two-wire bus front end of a timekeeping peripheral. It recognises its own 7-bit bus address, takes bytes from a bus master, and turns them into single-cycle read and write strobes on a 64-byte register space. The first eight bytes of that space hold clock and control values and the other 56 are plain RAM. The register array and the clock counters sit outside the block. The block supplies an address, write data and strobes, and it takes back the read byte in the same cycle.

A master writes by sending the device address with the direction bit clear. Its first following byte sets the internal pointer, and each byte after that is stored at the pointer, which then moves on. A master reads by sending the address with the direction bit set. The slave then shifts out bytes starting at whatever the pointer holds, so the master may set the pointer first with a write and a repeated START, or read straight from the last stored position. The bus lines are oversampled by a system clock that runs much faster than SCL. SDA is driven only as an open-drain pull-down enable. A power-fail input deselects the block at once.

Top module: `rtc_i2c_regport`

## Requirements
- R1: After reset the slave does not pull SDA low and the pointer (reg_addr) is 0.
- R2: Only the address byte 1101000 plus the direction bit (0xD0 write, 0xD1 read) is acknowledged. Any other address gets no ACK, and no strobe is issued until the next START.
- R3: In a write, the slave acknowledges the address byte, the word-address byte and every data byte. The word address loads the pointer. Each later byte is presented with reg_wr at the pointer, and the pointer then rises by one.
- R4: In a read, the byte at the pointer is shifted out MSB first. The pointer rises by one only when the master returns ACK (SDA low in the ninth clock). After a NACK the slave leaves SDA released.
- R5: A read that is not preceded by a pointer write starts at the pointer value left by earlier accesses, or at 0 straight after reset.
- R6: The pointer wraps from 63 to 0, for both writes and acknowledged reads.
- R7: A repeated START inside a transfer returns the slave to address reception and keeps the pointer.
- R8: While pwr_fail is high, the slave releases SDA and holds the pointer at 0 within one clock. It ignores all bus activity, including full write transfers, and issues no strobes.
- R9: The slave changes its SDA drive only while SCL is low, except when power-fail forces a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| pwr_fail | input | 1 | Supply out of tolerance: abort and lock out |
| reg_addr | output | 6 | Register pointer, address for both strobes |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to store when reg_wr is high |
| reg_rd | output | 1 | One-cycle fetch strobe; reg_rdata is taken in that cycle |
| reg_rdata | input | 8 | Register byte at reg_addr |

## Verification
The bench goes after the places where the pointer can drift. A design that advanced the pointer on a NACK would return the wrong byte on the next read without a pointer write. A design that forgot the pointer on a repeated START would read back from the wrong address. A design that did not wrap would miss the write to location 0. The bench also sends foreign addresses: a loose address compare would ACK them and issue stray writes. It runs full transfers during power-fail: a weak lock-out would let a byte through, or would keep the pointer instead of clearing it.

// File: rtl/rtc_i2c_regport.sv
`timescale 1ns/1ps
module rtc_i2c_regport #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic          pwr_fail,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [7:0]    reg_wdata,
  output logic          reg_rd,
  input  logic [7:0]    reg_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic rw, first, mack, oe;
  logic [AW-1:0] ptr;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire start_ev = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise = scl_s & ~scl_q;
  wire fall = ~scl_s & scl_q;
  wire byte_done = (cnt == 4'd8);
  wire hit = (sh[7:1] == DEV_ADDR);

  assign sda_oe    = oe;
  assign reg_addr  = ptr;
  assign reg_wdata = sh;
  assign reg_wr = ~pwr_fail & ~start_ev & ~stop_ev & (st == S_RX) & fall & byte_done & ~first;
  assign reg_rd = ~pwr_fail & ~start_ev & ~stop_ev & fall &
                  (((st == S_AACK) & rw) | ((st == S_TACK) & mack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0;
      first <= 1'b0; mack <= 1'b0; oe <= 1'b0; ptr <= '0;
    end else if (pwr_fail) begin
      st <= S_IDLE; cnt <= '0; oe <= 1'b0; ptr <= '0; mack <= 1'b0;
    end else if (start_ev) begin
      st <= S_ADDR; cnt <= '0; oe <= 1'b0;
    end else if (stop_ev) begin
      st <= S_IDLE; oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_RX: begin
          if (rise && !byte_done) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (fall && byte_done) begin
            if (st == S_ADDR) begin
              if (hit) begin
                oe <= 1'b1; rw <= sh[0]; st <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              oe <= 1'b1;
              st <= S_RACK;
              first <= 1'b0;
              if (first) ptr <= sh[AW-1:0];
              else       ptr <= ptr + 1'b1;
            end
          end
        end
        S_AACK: if (fall) begin
          cnt <= '0;
          if (rw) begin
            sh <= reg_rdata; oe <= ~reg_rdata[7]; st <= S_TX;
          end else begin
            oe <= 1'b0; first <= 1'b1; st <= S_RX;
          end
        end
        S_RACK: if (fall) begin
          oe <= 1'b0; cnt <= '0; st <= S_RX;
        end
        S_TX: begin
          if (rise && !byte_done) cnt <= cnt + 4'd1;
          else if (fall) begin
            if (byte_done) begin
              oe <= 1'b0; st <= S_TACK;
            end else begin
              sh <= {sh[6:0], 1'b0}; oe <= ~sh[6];
            end
          end
        end
        S_TACK: begin
          if (rise) begin
            mack <= ~sda_s;
            if (!sda_s) ptr <= ptr + 1'b1;
          end else if (fall) begin
            cnt <= '0;
            if (mack) begin
              sh <= reg_rdata; oe <= ~reg_rdata[7]; st <= S_TX;
            end else begin
              oe <= 1'b0; st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  pf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (!sda_oe && reg_addr == '0));

  // R8
  pf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> (!reg_wr && !reg_rd));

  // R3
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> sda_oe);

  // R6
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_addr == AW'($past(reg_addr) + 1'b1));

  // R9
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && !pwr_fail && !$past(pwr_fail)) |-> $stable(sda_oe));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd}));
endmodule

// File: tb/rtc_i2c_regport_bench.sv
`timescale 1ns/1ps
module rtc_i2c_regport_bench;
  localparam int HQ = 10;
  localparam logic [7:0] WA = 8'hD0, RA = 8'hD1;
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{16'h00_5A, 16'h01_A5, 16'h07_80, 16'h08_3C,
                                        16'h21_FF, 16'h2F_00, 16'h3E_7E, 16'h3F_C1};

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, pwr_fail = 1'b0;
  logic sda_oe, reg_wr, reg_rd;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [64];
  int total = 0, bad = 0, wr_cnt = 0, hold_bad = 0;
  logic prev_scl = 1'b1, prev_oe = 1'b0, prev_pf = 1'b0, done = 1'b0;
  wire sda_line = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  rtc_i2c_regport u_rtc_i2c_regport (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .pwr_fail(pwr_fail), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end

  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && !pwr_fail && !prev_pf && sda_oe != prev_oe)
      hold_bad <= hold_bad + 1;
    prev_scl <= m_scl; prev_oe <= sda_oe; prev_pf <= pwr_fail;
  end

  task automatic hq(); repeat (HQ) @(negedge clk); endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    if (!m_scl) begin m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); end
    m_sda = 1'b0; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hq(); m_scl = 1'b1; hq(); m_sda = 1'b1; hq(); hq();
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hq(); m_scl = 1'b1; hq(); hq(); m_scl = 1'b0;
    end
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); ack = ~sda_line; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic rx_byte(output logic [7:0] b, input logic give_ack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq(); m_scl = 1'b1; hq(); b[i] = sda_line; hq(); m_scl = 1'b0;
    end
    m_sda = ~give_ack; hq(); m_scl = 1'b1; hq(); hq(); m_scl = 1'b0; hq(); m_sda = 1'b1;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    int w0;
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 3 + 1);
    repeat (5) @(negedge clk);
    chk("R1 sda_oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 pointer after reset", int'(reg_addr), 0);

    // R5: pointer-less read right after reset starts at 0
    bus_start(); tx_byte(RA, a); chk("R2 read address ack", int'(a), 1);
    rx_byte(d, 1'b0); bus_stop();
    chk("R5 read at reset pointer", int'(d), 1);
    chk("R4 nack keeps pointer", int'(reg_addr), 0);

    // table: write one byte, read it back through a repeated START (R3 R4 R7)
    for (int v = 0; v < NV; v++) begin
      bus_start(); tx_byte(WA, a); tx_byte(VEC[v][15:8], a);
      tx_byte(VEC[v][7:0], a); chk("R3 data byte ack", int'(a), 1); bus_stop();
      bus_start(); tx_byte(WA, a); tx_byte(VEC[v][15:8], a);
      bus_start(); tx_byte(RA, a); chk("R7 ack after repeated start", int'(a), 1);
      rx_byte(d, 1'b0); bus_stop();
      chk("R7 readback via repeated start", int'(d), int'(VEC[v][7:0]));
    end

    // R3: burst write 10..15, pointer ends at 16
    bus_start(); tx_byte(WA, a); tx_byte(8'd10, a);
    for (int k = 0; k < 6; k++) tx_byte(8'(8'h90 + k), a);
    bus_stop();
    chk("R3 pointer after burst", int'(reg_addr), 16);
    chk("R3 burst stored first", int'(mem[10]), 8'h90);
    chk("R3 burst stored last", int'(mem[15]), 8'h95);

    // R5 R4: set pointer only, then read without a pointer write
    bus_start(); tx_byte(WA, a); tx_byte(8'd14, a); bus_stop();
    bus_start(); tx_byte(RA, a);
    rx_byte(d, 1'b1); chk("R5 first byte at stored pointer", int'(d), 8'h94);
    rx_byte(d, 1'b0); chk("R4 sequential read byte", int'(d), 8'h95);
    bus_stop();
    chk("R4 pointer moved on ack only", int'(reg_addr), 15);
    chk("R4 sda released after nack", int'(sda_oe), 0);

    // R6: wrap on write and read
    bus_start(); tx_byte(WA, a); tx_byte(8'd62, a);
    tx_byte(8'hA1, a); tx_byte(8'hB2, a); tx_byte(8'hC3, a); bus_stop();
    chk("R6 write wrap to zero", int'(mem[0]), 8'hC3);
    chk("R6 pointer after write wrap", int'(reg_addr), 1);
    bus_start(); tx_byte(WA, a); tx_byte(8'd63, a);
    bus_start(); tx_byte(RA, a);
    rx_byte(d, 1'b1); chk("R6 read at 63", int'(d), 8'hB2);
    rx_byte(d, 1'b0); chk("R6 read wrapped to 0", int'(d), 8'hC3);
    bus_stop();
    chk("R6 pointer after read wrap", int'(reg_addr), 0);

    // R2: foreign addresses are not acknowledged and write nothing
    w0 = wr_cnt;
    bus_start(); tx_byte(8'hA0, a); chk("R2 no ack for 0xA0", int'(a), 0);
    tx_byte(8'h05, a); tx_byte(8'h66, a); chk("R2 no ack after foreign address", int'(a), 0);
    bus_stop();
    bus_start(); tx_byte(8'hD2, a); chk("R2 no ack for 0xD2", int'(a), 0); bus_stop();
    chk("R2 no stray writes", wr_cnt - w0, 0);

    // R8: power-fail aborts, clears the pointer and locks out
    bus_start(); tx_byte(WA, a); tx_byte(8'd20, a); tx_byte(8'h11, a); bus_stop();
    bus_start(); tx_byte(WA, a); tx_byte(8'd20, a);
    w0 = wr_cnt;
    for (int i = 7; i >= 4; i--) begin
      m_sda = i[0]; hq(); m_scl = 1'b1; hq(); hq(); m_scl = 1'b0;
    end
    pwr_fail = 1'b1; repeat (3) @(negedge clk);
    chk("R8 sda released", int'(sda_oe), 0);
    chk("R8 pointer cleared", int'(reg_addr), 0);
    for (int i = 3; i >= 0; i--) begin
      m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); hq(); m_scl = 1'b0;
    end
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); hq(); m_scl = 1'b0; hq();
    bus_stop();
    bus_start(); tx_byte(WA, a); chk("R8 no ack while power fails", int'(a), 0);
    tx_byte(8'd20, a); tx_byte(8'h77, a); bus_stop();
    chk("R8 no writes while power fails", wr_cnt - w0, 0);
    pwr_fail = 1'b0; repeat (4) @(negedge clk);
    chk("R8 pointer still zero after recovery", int'(reg_addr), 0);
    bus_start(); tx_byte(WA, a); tx_byte(8'd20, a);
    bus_start(); tx_byte(RA, a); rx_byte(d, 1'b0); bus_stop();
    chk("R8 location untouched", int'(d), 8'h11);

    chk("R9 drive changes while SCL high", hold_bad, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule